// File: doc/BRIEF.md
# Folding Instruction Queue

This block sits between instruction fetch and dispatch in a small superscalar core. Each cycle it can take a fetch group of up to four instruction words, along with the address of the first slot and a per-slot valid mask. As the words arrive, a branch pre-decoder looks at every slot. Branches that write neither the count nor the link register need no execution unit, so they never enter storage. When such a branch is taken, either unconditionally or by static prediction, the fetch address is steered to its target and the younger slots of the same group are dropped. Branches that write the count or link register stay in the stream and carry a flag.

The two oldest entries are always visible to dispatch, together with their addresses and branch flags. Dispatch says how many of them it takes each cycle. The queue holds six entries and tells fetch to stall whenever a full group might not fit. A flush input empties the queue at once and reloads the fetch address from a supplied restart value.

Branch pre-decode uses this encoding. Bits [31:28] equal to 4'hB mark a branch. Bit 27 set means the branch is conditional. Bit 26 set means it writes the count or link register. Bits [15:0] hold a signed word displacement, and the target is the slot address plus the sign-extended displacement shifted left by two. Slot k of a group sits at the group address plus 4*k.

Top module: `instr_queue_fold`

## Requirements
- R1: A fetch group is accepted in the cycle where `fetch_vld_i` is high, `full_o` is low and `flush_i` is low. Its surviving slots enter the queue in slot order, and slots whose mask bit is 0 are skipped entirely, even if they hold a branch.
- R2: A valid-slot branch with bit 26 clear is never written into the queue.
- R3: A valid folded branch is taken if it is unconditional (bit 27 = 0), or if it is conditional with a negative displacement (bit 15 = 1). After accepting a group, the cycle that follows shows `redir_o` = 1 and `fetch_pc_o` equal to the target of the oldest such branch.
- R4: A folded conditional branch with a forward displacement is predicted not taken. If no taken fold is in the group, the cycle after acceptance shows `redir_o` = 0 and `fetch_pc_o` = group address + 16.
- R5: Every slot younger than the oldest taken folded branch of a group is discarded.
- R6: A valid branch with bit 26 set is queued with its `hd_br_o` flag at 1 and causes no redirect. All other queued words have the flag at 0.
- R7: Lane 0 of the head outputs carries the oldest entry and lane 1 the next oldest. `hd_vld_o[i]` is 1 when more than i entries are held, and `disp_take_i` (0 to 2) removes that many entries from the head at the clock edge.
- R8: `full_o` is 1 exactly when more than two of the six entries are occupied. A group offered while `full_o` is 1 is not stored, and it leaves `fetch_pc_o` unchanged with `redir_o` = 0.
- R9: A flush empties the queue in one cycle, and the next cycle shows `fetch_pc_o` = `flush_pc_i` with a one-cycle `redir_o` pulse. A fetch group or consume request in the flush cycle has no effect.
- R10: After reset the queue is empty, `full_o` = 0, `redir_o` = 0 and `fetch_pc_o` equals the `RESET_PC` parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fetch_vld_i | input | 1 | A fetch group is offered |
| fetch_pc_i | input | 32 | Address of slot 0 of the group |
| fetch_mask_i | input | 4 | Per-slot valid mask |
| fetch_word_i | input | 128 | Slot k word in bits [32k+31:32k] |
| disp_take_i | input | 2 | Number of head entries consumed this cycle |
| flush_i | input | 1 | Empty the queue and restart fetch |
| flush_pc_i | input | 32 | Restart address for a flush |
| fetch_pc_o | output | 32 | Next fetch address |
| redir_o | output | 1 | Fetch address changed by a taken fold or flush |
| full_o | output | 1 | Stall fetch: fewer than four free entries |
| hd_vld_o | output | 2 | Head lane valid flags |
| hd_word_o | output | 64 | Head lane instruction words, lane i in [32i+31:32i] |
| hd_pc_o | output | 64 | Head lane addresses |
| hd_br_o | output | 2 | Head lane kept-branch flags |

## Verification
The assertions rely on three input rules. Dispatch never asks for more entries than the head lanes show valid. A flush is a single synchronous pulse. A rejected group is simply offered again later. The bench follows these rules in two ways: its consumer picks a random take count and limits it to the number of valid head lanes, and its fetch driver waits for `full_o` to drop before offering a group. The one exception is the directed overflow probe, where a group is deliberately offered into a full queue.

// File: rtl/iq_pkg.sv
package iq_pkg;
  localparam int ILEN = 32;
  localparam int ALEN = 32;
  localparam int DISP_W = 16;
  localparam int BR_COND_BIT = 27;
  localparam int BR_LINK_BIT = 26;
  localparam logic [3:0] BR_MAJOR = 4'hB;

  typedef struct packed {
    logic [ILEN-1:0] word;
    logic [ALEN-1:0] pc;
    logic            is_br;
  } iq_ent_t;

  function automatic logic [ALEN-1:0] br_offset(input logic [ILEN-1:0] w);
    return {{(ALEN-DISP_W-2){w[DISP_W-1]}}, w[DISP_W-1:0], 2'b00};
  endfunction
endpackage

// File: rtl/iq_predecode.sv
module iq_predecode
  import iq_pkg::*;
#(
  parameter int FW = 4
) (
  input  logic [ALEN-1:0]    pc_i,
  input  logic [FW*ILEN-1:0] word_i,
  input  logic [FW-1:0]      mask_i,
  output logic [FW-1:0]      keep_o,
  output iq_ent_t [FW-1:0]   ent_o,
  output logic               taken_o,
  output logic [ALEN-1:0]    target_o
);
  localparam int SLOT_BYTES = ILEN / 8;

  always_comb begin
    logic            killed;
    logic [ILEN-1:0] w;
    logic [ALEN-1:0] spc;
    logic            isb, fold, tk;
    killed   = 1'b0;
    taken_o  = 1'b0;
    target_o = '0;
    keep_o   = '0;
    ent_o    = '0;
    for (int k = 0; k < FW; k++) begin
      w    = word_i[k*ILEN +: ILEN];
      spc  = pc_i + ALEN'(k * SLOT_BYTES);
      isb  = (w[ILEN-1 -: 4] == BR_MAJOR);
      fold = mask_i[k] & isb & ~w[BR_LINK_BIT];
      tk   = fold & (~w[BR_COND_BIT] | w[DISP_W-1]);
      keep_o[k] = mask_i[k] & ~fold & ~killed;
      ent_o[k]  = '{word: w, pc: spc, is_br: isb & w[BR_LINK_BIT]};
      if (tk && !killed) begin
        taken_o  = 1'b1;
        target_o = spc + br_offset(w);
      end
      killed = killed | tk;
    end
  end
endmodule

// File: rtl/iq_store.sv
module iq_store
  import iq_pkg::*;
#(
  parameter int DEPTH = 6,
  parameter int FW    = 4,
  parameter int DW    = 2,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int QW   = $clog2(DW + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic              enq_i,
  input  logic [FW-1:0]     keep_i,
  input  iq_ent_t [FW-1:0]  ent_i,
  input  logic [QW-1:0]     deq_i,
  output iq_ent_t [DW-1:0]  head_o,
  output logic [DW-1:0]     head_vld_o,
  output logic [CW-1:0]     count_o
);
  iq_ent_t        mem_q [DEPTH];
  iq_ent_t        wdata [DEPTH];
  logic [DEPTH-1:0] we;
  logic [PW-1:0]  head_q, head_n;
  logic [CW-1:0]  cnt_q, cnt_n;
  logic           upd;

  function automatic logic [PW-1:0] wrap(input int x);
    return PW'(x % DEPTH);
  endfunction

  // next state: compacted write positions, head and occupancy
  always_comb begin
    int tail, off;
    we  = '0;
    off = 0;
    for (int e = 0; e < DEPTH; e++) wdata[e] = '0;
    tail = int'(head_q) + int'(cnt_q);
    for (int k = 0; k < FW; k++) begin
      if (enq_i && keep_i[k]) begin
        we[wrap(tail + off)]    = 1'b1;
        wdata[wrap(tail + off)] = ent_i[k];
        off = off + 1;
      end
    end
    if (flush_i) begin
      head_n = '0;
      cnt_n  = '0;
    end else begin
      head_n = wrap(int'(head_q) + int'(deq_i));
      cnt_n  = CW'(int'(cnt_q) - int'(deq_i) + off);
    end
    upd = flush_i | enq_i | (deq_i != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      cnt_q  <= '0;
    end else if (upd) begin
      head_q <= head_n;
      cnt_q  <= cnt_n;
    end
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    always_ff @(posedge clk) begin
      if (we[e]) mem_q[e] <= wdata[e];
    end
  end

  always_comb begin
    for (int d = 0; d < DW; d++) begin
      head_o[d]     = mem_q[wrap(int'(head_q) + d)];
      head_vld_o[d] = (int'(cnt_q) > d);
    end
  end

  assign count_o = cnt_q;

  // R7: occupancy never exceeds the storage
  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  // R7: dispatch never takes more than is held (input rule)
  p_take_le_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !flush_i |-> (int'(deq_i) <= int'(cnt_q)));
  // R8: without an enqueue the occupancy cannot grow
  p_no_grow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !enq_i |=> cnt_q <= $past(cnt_q));
  // R9: a flush leaves the queue empty
  p_flush_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (cnt_q == '0) && (head_vld_o == '0));
endmodule

// File: rtl/instr_queue_fold.sv
module instr_queue_fold
  import iq_pkg::*;
#(
  parameter int DEPTH = 6,
  parameter int FW    = 4,
  parameter int DW    = 2,
  parameter logic [31:0] RESET_PC = 32'h0000_1000,
  localparam int QW   = $clog2(DW + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fetch_vld_i,
  input  logic [ALEN-1:0]     fetch_pc_i,
  input  logic [FW-1:0]       fetch_mask_i,
  input  logic [FW*ILEN-1:0]  fetch_word_i,
  input  logic [QW-1:0]       disp_take_i,
  input  logic                flush_i,
  input  logic [ALEN-1:0]     flush_pc_i,
  output logic [ALEN-1:0]     fetch_pc_o,
  output logic                redir_o,
  output logic                full_o,
  output logic [DW-1:0]       hd_vld_o,
  output logic [DW*ILEN-1:0]  hd_word_o,
  output logic [DW*ALEN-1:0]  hd_pc_o,
  output logic [DW-1:0]       hd_br_o
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int GROUP_BYTES = FW * (ILEN / 8);

  // reset: asserted asynchronously, released on the clock
  logic rs_meta, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rst_s   <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rst_s   <= rs_meta;
    end
  end

  logic [FW-1:0]    keep;
  iq_ent_t [FW-1:0] ent;
  logic             taken;
  logic [ALEN-1:0]  target;
  iq_ent_t [DW-1:0] head;
  logic [CW-1:0]    count;
  logic             accept;

  iq_predecode #(.FW(FW)) u_pdec (
    .pc_i     (fetch_pc_i),
    .word_i   (fetch_word_i),
    .mask_i   (fetch_mask_i),
    .keep_o   (keep),
    .ent_o    (ent),
    .taken_o  (taken),
    .target_o (target)
  );

  assign full_o = (count > CW'(DEPTH - FW));
  assign accept = fetch_vld_i & ~full_o & ~flush_i;

  iq_store #(.DEPTH(DEPTH), .FW(FW), .DW(DW)) u_store (
    .clk        (clk),
    .rst_n      (rst_s),
    .flush_i    (flush_i),
    .enq_i      (accept),
    .keep_i     (keep),
    .ent_i      (ent),
    .deq_i      (disp_take_i),
    .head_o     (head),
    .head_vld_o (hd_vld_o),
    .count_o    (count)
  );

  always_comb begin
    for (int d = 0; d < DW; d++) begin
      hd_word_o[d*ILEN +: ILEN] = head[d].word;
      hd_pc_o[d*ALEN +: ALEN]   = head[d].pc;
      hd_br_o[d]                = head[d].is_br;
    end
  end

  // fetch address steering
  logic [ALEN-1:0] pc_n;
  logic            redir_n, pc_en;
  always_comb begin
    pc_n    = fetch_pc_o;
    redir_n = 1'b0;
    pc_en   = flush_i | accept;
    if (flush_i) begin
      pc_n    = flush_pc_i;
      redir_n = 1'b1;
    end else if (accept) begin
      pc_n    = taken ? target : fetch_pc_i + ALEN'(GROUP_BYTES);
      redir_n = taken;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      fetch_pc_o <= RESET_PC;
      redir_o    <= 1'b0;
    end else begin
      redir_o <= redir_n;
      if (pc_en) fetch_pc_o <= pc_n;
    end
  end

  // R3: a taken fold steers fetch to its target
  p_taken_redir_r3: assert property (@(posedge clk) disable iff (!rst_s)
    (accept && taken) |=> redir_o && (fetch_pc_o == $past(target)));
  // R4: no taken fold means sequential fetch
  p_seq_fetch_r4: assert property (@(posedge clk) disable iff (!rst_s)
    (accept && !taken) |=> !redir_o && (fetch_pc_o == $past(fetch_pc_i) + ALEN'(GROUP_BYTES)));
  // R8: a group refused by backpressure changes nothing at fetch
  p_hold_when_full_r8: assert property (@(posedge clk) disable iff (!rst_s)
    (fetch_vld_i && full_o && !flush_i) |=> !redir_o && $stable(fetch_pc_o));
  // R9: flush restarts fetch at the supplied address
  p_flush_restart_r9: assert property (@(posedge clk) disable iff (!rst_s)
    flush_i |=> redir_o && (fetch_pc_o == $past(flush_pc_i)));
endmodule

// File: tb/sim_instr_queue_fold.sv
`timescale 1ns/1ps
module sim_instr_queue_fold;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         fetch_vld;
  logic [31:0]  fetch_pc;
  logic [3:0]   fetch_mask;
  logic [127:0] fetch_word;
  logic [1:0]   disp_take;
  logic         flush;
  logic [31:0]  flush_pc;
  logic [31:0]  fpc;
  logic         redir, full;
  logic [1:0]   hd_vld, hd_br;
  logic [63:0]  hd_word, hd_pc;

  localparam logic [31:0] RST_PC = 32'h0000_1000;

  always #4 clk = ~clk;

  instr_queue_fold u0 (
    .clk(clk), .rst_n(rst_n), .fetch_vld_i(fetch_vld), .fetch_pc_i(fetch_pc),
    .fetch_mask_i(fetch_mask), .fetch_word_i(fetch_word), .disp_take_i(disp_take),
    .flush_i(flush), .flush_pc_i(flush_pc), .fetch_pc_o(fpc), .redir_o(redir),
    .full_o(full), .hd_vld_o(hd_vld), .hd_word_o(hd_word), .hd_pc_o(hd_pc), .hd_br_o(hd_br)
  );

  typedef struct {
    logic [31:0] w;
    logic [31:0] pc;
    logic        br;
    string       tag;
  } exp_t;
  exp_t sb[$];

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  cons_en = 1'b1;
  bit  done    = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] nrm(input int i);
    return 32'h1000_0000 | 32'(i);
  endfunction
  function automatic logic [31:0] brw(input bit c, input bit l, input logic [15:0] d);
    return {4'hB, c, l, 10'h0, d};
  endfunction
  function automatic logic [3:0][31:0] pk(input logic [31:0] a, b, c, d);
    return {d, c, b, a};
  endfunction

  // driver: model the expected stream and redirect, then offer the group
  task automatic send(input logic [31:0] pc, input logic [3:0][31:0] ins,
                      input logic [3:0] m, input string tag, input bit wait_full);
    bit kill, tk, acc, isb, fold, t;
    logic [31:0] tgt, pck, old_pc;
    exp_t e;
    if (wait_full) while (full) @(negedge clk);
    acc = !full;
    old_pc = fpc;
    kill = 0; tk = 0; tgt = '0;
    for (int k = 0; k < 4; k++) begin
      pck  = pc + 32'(4 * k);
      isb  = (ins[k][31:28] == 4'hB);
      fold = m[k] & isb & ~ins[k][26];
      t    = fold & (~ins[k][27] | ins[k][15]);
      if (acc && m[k] && !fold && !kill) begin
        e.w = ins[k]; e.pc = pck; e.br = isb & ins[k][26]; e.tag = tag;
        sb.push_back(e);
      end
      if (t && !kill) begin
        tk  = 1;
        tgt = pck + {{14{ins[k][15]}}, ins[k][15:0], 2'b00};
      end
      if (t) kill = 1;
    end
    fetch_pc = pc; fetch_word = ins; fetch_mask = m; fetch_vld = 1'b1;
    @(negedge clk);
    fetch_vld = 1'b0;
    if (acc) begin
      chk(redir == tk, tag, "redirect flag", 32'(redir), 32'(tk));
      chk(fpc == (tk ? tgt : pc + 32'd16), tag, "next fetch pc", fpc, tk ? tgt : pc + 32'd16);
    end else begin
      chk(redir == 1'b0, tag, "redirect on refused group", 32'(redir), 32'd0);
      chk(fpc == old_pc, tag, "fetch pc on refused group", fpc, old_pc);
    end
  endtask

  // monitor: consume a random number of valid heads and compare them
  initial begin
    disp_take = '0;
    forever begin
      @(negedge clk);
      if (!cons_en || !rst_n) disp_take = '0;
      else begin
        int n, c;
        n = int'(hd_vld[0]) + int'(hd_vld[1]);
        c = int'($urandom % 3);
        if (c > n) c = n;
        for (int d = 0; d < c; d++) begin
          exp_t e;
          if (sb.size() == 0) begin
            chk(1'b0, "R7", "dequeued entry with empty scoreboard", hd_word[d*32 +: 32], 32'd0);
          end else begin
            e = sb.pop_front();
            chk(hd_word[d*32 +: 32] == e.w && hd_pc[d*32 +: 32] == e.pc && hd_br[d] == e.br,
                e.tag, $sformatf("lane %0d word (pc %h br %0d)", d, hd_pc[d*32 +: 32], hd_br[d]),
                hd_word[d*32 +: 32], e.w);
          end
        end
        disp_take = 2'(c);
      end
    end
  end

  task automatic drain();
    cons_en = 1'b1;
    while (sb.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "R7", "watchdog: run completed", 32'd0, 32'd1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; fetch_vld = 1'b0; fetch_pc = '0; fetch_mask = '0; fetch_word = '0;
    flush = 1'b0; flush_pc = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10 reset state
    chk(hd_vld == 2'b00, "R10", "head valid after reset", 32'(hd_vld), 32'd0);
    chk(full == 1'b0, "R10", "full after reset", 32'(full), 32'd0);
    chk(redir == 1'b0, "R10", "redirect after reset", 32'(redir), 32'd0);
    chk(fpc == RST_PC, "R10", "fetch pc after reset", fpc, RST_PC);

    send(32'h0000_1000, pk(nrm(1), nrm(2), nrm(3), nrm(4)), 4'hF, "R1 full group", 1);
    send(32'h0000_1010, pk(nrm(5), nrm(6), nrm(7), nrm(8)), 4'b1010, "R1 sparse mask", 1);
    // R2 R3 R5: unconditional fold at slot 1, slots 2..3 dropped
    send(32'h0000_2000, pk(nrm(9), brw(0, 0, 16'h0040), nrm(10), nrm(11)), 4'hF, "R2 R3 R5 uncond fold", 1);
    // R3: backward conditional fold predicted taken at slot 2
    send(32'h0000_3000, pk(nrm(12), nrm(13), brw(1, 0, 16'hFFF0), nrm(14)), 4'hF, "R3 backward cond", 1);
    // R4: forward conditional fold, sequential fetch, younger slots kept
    send(32'h0000_4000, pk(brw(1, 0, 16'h0010), nrm(15), nrm(16), nrm(17)), 4'hF, "R4 forward cond", 1);
    // R6: link-writing branch queued with flag, no redirect
    send(32'h0000_5000, pk(nrm(18), brw(0, 1, 16'hFF00), nrm(19), nrm(20)), 4'hF, "R6 kept branch", 1);
    // R1: a masked-off taken branch has no effect
    send(32'h0000_6000, pk(nrm(21), brw(0, 0, 16'h0100), nrm(22), nrm(23)), 4'b0101, "R1 masked branch", 1);
    // R4 R5: forward not-taken then taken fold in one group
    send(32'h0000_6100, pk(brw(1, 0, 16'h0004), nrm(24), brw(0, 0, 16'hFFFC), nrm(25)), 4'hF, "R4 R5 two folds", 1);
    drain();

    // R7: random traffic following the steered fetch address
    for (int g = 0; g < 60; g++) begin
      logic [3:0][31:0] ins;
      logic [3:0] m;
      for (int k = 0; k < 4; k++) begin
        int r;
        r = int'($urandom % 8);
        case (r)
          0:       ins[k] = brw(0, 0, 16'($urandom));
          1:       ins[k] = brw(1, 0, 16'($urandom));
          2:       ins[k] = brw(1, 1, 16'($urandom));
          default: ins[k] = {4'h2, 28'($urandom)};
        endcase
      end
      m = ($urandom % 2 == 0) ? 4'hF : 4'($urandom);
      send(fpc, ins, m, "R7 random", 1);
    end
    drain();
    chk(hd_vld == 2'b00, "R7", "head valid after drain", 32'(hd_vld), 32'd0);

    // R8: backpressure threshold
    cons_en = 1'b0;
    @(negedge clk);
    send(32'h0000_7000, pk(nrm(30), nrm(31), nrm(32), nrm(33)), 4'b0011, "R8 two held", 1);
    chk(full == 1'b0, "R8", "full with two held", 32'(full), 32'd0);
    send(32'h0000_7100, pk(nrm(34), nrm(35), nrm(36), nrm(37)), 4'hF, "R8 fill to six", 1);
    chk(full == 1'b1, "R8", "full with six held", 32'(full), 32'd1);
    chk(hd_vld == 2'b11, "R7", "both heads valid", 32'(hd_vld), 32'd3);
    send(32'h0000_7200, pk(nrm(40), nrm(41), nrm(42), nrm(43)), 4'hF, "R8 refused group", 0);
    drain();

    // R9: flush with a simultaneous fetch group
    cons_en = 1'b0;
    @(negedge clk);
    send(32'h0000_8000, pk(nrm(50), nrm(51), nrm(52), nrm(53)), 4'hF, "R9 before flush", 1);
    flush = 1'b1; flush_pc = 32'h0000_9000;
    fetch_pc = 32'h0000_A000; fetch_word = pk(nrm(60), nrm(61), nrm(62), nrm(63));
    fetch_mask = 4'hF; fetch_vld = 1'b1;
    sb.delete();
    @(negedge clk);
    flush = 1'b0; fetch_vld = 1'b0;
    chk(hd_vld == 2'b00, "R9", "head valid after flush", 32'(hd_vld), 32'd0);
    chk(full == 1'b0, "R9", "full after flush", 32'(full), 32'd0);
    chk(redir == 1'b1, "R9", "redirect after flush", 32'(redir), 32'd1);
    chk(fpc == 32'h0000_9000, "R9", "fetch pc after flush", fpc, 32'h0000_9000);
    @(negedge clk);
    chk(redir == 1'b0, "R9", "redirect pulse ends", 32'(redir), 32'd0);
    chk(hd_vld == 2'b00, "R9", "fetch in flush cycle ignored", 32'(hd_vld), 32'd0);
    cons_en = 1'b1;
    send(fpc, pk(nrm(70), nrm(71), nrm(72), nrm(73)), 4'hF, "R9 after flush", 1);
    drain();

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule